// File: doc/BRIEF.md
# Not-Taken Branch Redirect and Squash Controller

This block steers instruction fetch in a five-stage in-order pipeline. It assumes that every conditional branch falls through. It owns the fetch program counter and the valid bits of the decode and execute pipeline registers.

Each cycle, the surrounding pipeline presents the instruction held in decode: a branch flag, its address, its immediate offset and its two register operands. A branch is taken when the two operands are equal.

A static mode input selects where branches resolve:
- **Decode resolution.** A dedicated adder and comparator act in decode. A taken branch squashes one wrong-path instruction.
- **Execute resolution.** The branch record travels into the execute register and is resolved there. A taken branch squashes two wrong-path instructions.

Squashing clears valid bits, so wrong-path work never reaches the later stages. The pipeline logs an instruction as retired when it occupies a valid slot in execute.

Top module: `bfc_flush_ctrl`

## Requirements
- R1: While `rst` is high, the block clears state on each clock edge. At the next edge `fetch_pc` equals `RESET_PC`, and `id_valid`, `ex_valid`, `flush_ifid` and `flush_idex` are all 0.
- R2: With no stall and no redirect, `fetch_pc` grows by 4 at each edge. Straight-line code then places one valid instruction in execute per cycle, starting two cycles after reset is released.
- R3: A branch is taken only when `id_opnd_a` equals `id_opnd_b`. A branch that is not taken adds no cycle to the retirement schedule.
- R4: The target is the branch address plus the sign-extended `id_offset` multiplied by 4. Negative offsets branch backwards.
- R5: With `resolve_in_id` = 0, a taken branch asserts `flush_ifid` and `flush_idex` together for one cycle, while the branch sits in execute. Its target enters execute three cycles after the branch, which is a penalty of 2.
- R6: With `resolve_in_id` = 1, a taken branch asserts only `flush_ifid`, while the branch sits in decode. `flush_idex` never rises, and the target enters execute two cycles after the branch, which is a penalty of 1.
- R7: The sequence of addresses seen valid in execute equals the architectural path of the program. No squashed instruction ever appears valid.
- R8: A branch that lies on a squashed path never redirects fetch, even if its operands are equal.
- R9: When `hazard_stall` is high and no redirect happens, `fetch_pc` and the decode slot hold, and a bubble enters execute. Each such cycle delays all later retirements by one cycle.
- R10: A taken-branch redirect in the same cycle as `hazard_stall` wins over the stall. Fetch is redirected, and in decode-resolution mode the branch still advances to execute, so the branch penalty is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| resolve_in_id | input | 1 | 1: resolve branches in decode; 0: resolve in execute (static) |
| hazard_stall | input | 1 | Data-hazard stall request for the decode instruction |
| id_is_branch | input | 1 | Decode-stage instruction is a conditional branch |
| id_pc | input | XLEN | Address of the decode-stage instruction |
| id_offset | input | OFS_W | Signed word offset of the decode-stage branch |
| id_opnd_a | input | XLEN | First compared operand |
| id_opnd_b | input | XLEN | Second compared operand |
| fetch_pc | output | XLEN | Registered fetch address |
| flush_ifid | output | 1 | Fetch/decode register receives a bubble at the next edge |
| flush_idex | output | 1 | Decode/execute register receives a bubble at the next edge |
| id_valid | output | 1 | Decode slot holds a live instruction |
| ex_valid | output | 1 | Execute slot holds a live instruction |

## Verification
The hardest situation to reach is a taken branch followed directly by further taken branches on the wrong path, with equal operands. A faulty design would let one of them redirect fetch a second time. The harder case is the same pattern with a stall raised in exactly the redirect cycle.

The bench builds that program in a small instruction table. It then drives the stall from its own pipeline model, raising it precisely when a taken branch occupies the resolving stage. Retirement order and cycle times are compared against an architectural walk of the program in both resolution modes.

// File: rtl/bfc_pkg.sv
package bfc_pkg;
  localparam int unsigned INSN_BYTES = 4;
  localparam int unsigned INSN_SHIFT = 2;
  localparam int unsigned N_RES      = 2;
  localparam int unsigned RES_ID     = 0;
  localparam int unsigned RES_EX     = 1;

  typedef enum logic [1:0] {
    PC_SEQ      = 2'd0,
    PC_HOLD     = 2'd1,
    PC_REDIRECT = 2'd2
  } pc_sel_e;
endpackage

// File: rtl/bfc_branch_eval.sv
module bfc_branch_eval #(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned OFS_W = 12
) (
  input  logic [XLEN-1:0]  br_pc,
  input  logic [OFS_W-1:0] br_off,
  input  logic [XLEN-1:0]  opnd_a,
  input  logic [XLEN-1:0]  opnd_b,
  output logic             is_eq,
  output logic [XLEN-1:0]  target
);
  import bfc_pkg::*;
  localparam int unsigned EXT_W = XLEN - OFS_W;

  logic [XLEN-1:0] off_ext;

  always_comb begin
    off_ext = {{EXT_W{br_off[OFS_W-1]}}, br_off};
    target  = br_pc + (off_ext << INSN_SHIFT);
    is_eq   = (opnd_a == opnd_b);
  end
endmodule

// File: rtl/bfc_pc_reg.sv
module bfc_pc_reg #(
  parameter int unsigned        XLEN     = 32,
  parameter logic [XLEN-1:0]    RESET_PC = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  bfc_pkg::pc_sel_e sel,
  input  logic [XLEN-1:0] target,
  output logic [XLEN-1:0] pc_q
);
  import bfc_pkg::*;
  localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q <= RESET_PC;
    end else begin
      unique case (sel)
        PC_REDIRECT: pc_q <= target;
        PC_HOLD:     pc_q <= pc_q;
        default:     pc_q <= pc_q + STEP;
      endcase
    end
  end
endmodule

// File: rtl/bfc_stage_ctl.sv
module bfc_stage_ctl #(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned OFS_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hazard_stall,
  input  logic             id_fire,
  input  logic             ex_fire,
  input  logic             id_is_branch,
  input  logic [XLEN-1:0]  id_pc,
  input  logic [OFS_W-1:0] id_off,
  input  logic [XLEN-1:0]  id_a,
  input  logic [XLEN-1:0]  id_b,
  output logic             ifid_vld,
  output logic             idex_vld,
  output logic             ex_br,
  output logic [XLEN-1:0]  ex_pc,
  output logic [OFS_W-1:0] ex_off,
  output logic [XLEN-1:0]  ex_a,
  output logic [XLEN-1:0]  ex_b
);
  logic redirect;
  logic hold_id;

  always_comb begin
    redirect = id_fire | ex_fire;
    hold_id  = hazard_stall & ~redirect;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ifid_vld <= 1'b0;
      idex_vld <= 1'b0;
    end else begin
      if (redirect)          ifid_vld <= 1'b0;
      else if (!hold_id)     ifid_vld <= 1'b1;
      if (ex_fire || hold_id) idex_vld <= 1'b0;
      else                    idex_vld <= ifid_vld;
    end
  end

  always_ff @(posedge clk) begin
    ex_br  <= id_is_branch;
    ex_pc  <= id_pc;
    ex_off <= id_off;
    ex_a   <= id_a;
    ex_b   <= id_b;
  end

  // R9
  stall_bubble_chk: assert property (@(posedge clk) disable iff (rst)
    (hazard_stall && !id_fire && !ex_fire) |=> !idex_vld);

  // R7
  ex_squash_chk: assert property (@(posedge clk) disable iff (rst)
    ex_fire |=> (!idex_vld && !ifid_vld));

  // R8
  id_squash_chk: assert property (@(posedge clk) disable iff (rst)
    id_fire |=> !ifid_vld);
endmodule

// File: rtl/bfc_flush_ctrl.sv
module bfc_flush_ctrl #(
  parameter int unsigned     XLEN     = 32,
  parameter int unsigned     OFS_W    = 12,
  parameter logic [XLEN-1:0] RESET_PC = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             resolve_in_id,
  input  logic             hazard_stall,
  input  logic             id_is_branch,
  input  logic [XLEN-1:0]  id_pc,
  input  logic [OFS_W-1:0] id_offset,
  input  logic [XLEN-1:0]  id_opnd_a,
  input  logic [XLEN-1:0]  id_opnd_b,
  output logic [XLEN-1:0]  fetch_pc,
  output logic             flush_ifid,
  output logic             flush_idex,
  output logic             id_valid,
  output logic             ex_valid
);
  import bfc_pkg::*;

  logic             ifid_vld, idex_vld, ex_br;
  logic [XLEN-1:0]  ex_pc, ex_a, ex_b;
  logic [OFS_W-1:0] ex_off;

  logic [XLEN-1:0]  ev_pc  [N_RES];
  logic [OFS_W-1:0] ev_off [N_RES];
  logic [XLEN-1:0]  ev_a   [N_RES];
  logic [XLEN-1:0]  ev_b   [N_RES];
  logic [XLEN-1:0]  ev_tgt [N_RES];
  logic             ev_eq  [N_RES];

  logic             id_fire, ex_fire, redirect;
  logic [XLEN-1:0]  redir_tgt;
  pc_sel_e          pc_sel;

  always_comb begin
    ev_pc[RES_ID]  = id_pc;
    ev_off[RES_ID] = id_offset;
    ev_a[RES_ID]   = id_opnd_a;
    ev_b[RES_ID]   = id_opnd_b;
    ev_pc[RES_EX]  = ex_pc;
    ev_off[RES_EX] = ex_off;
    ev_a[RES_EX]   = ex_a;
    ev_b[RES_EX]   = ex_b;
  end

  for (genvar s = 0; s < N_RES; s++) begin : g_eval
    bfc_branch_eval #(.XLEN(XLEN), .OFS_W(OFS_W)) i_eval (
      .br_pc (ev_pc[s]),
      .br_off(ev_off[s]),
      .opnd_a(ev_a[s]),
      .opnd_b(ev_b[s]),
      .is_eq (ev_eq[s]),
      .target(ev_tgt[s])
    );
  end

  always_comb begin
    id_fire   = resolve_in_id & ifid_vld & id_is_branch & ev_eq[RES_ID];
    ex_fire   = ~resolve_in_id & idex_vld & ex_br & ev_eq[RES_EX];
    redirect  = id_fire | ex_fire;
    redir_tgt = ex_fire ? ev_tgt[RES_EX] : ev_tgt[RES_ID];
    if (redirect)          pc_sel = PC_REDIRECT;
    else if (hazard_stall) pc_sel = PC_HOLD;
    else                   pc_sel = PC_SEQ;
  end

  bfc_stage_ctl #(.XLEN(XLEN), .OFS_W(OFS_W)) i_stage (
    .clk         (clk),
    .rst         (rst),
    .hazard_stall(hazard_stall),
    .id_fire     (id_fire),
    .ex_fire     (ex_fire),
    .id_is_branch(id_is_branch),
    .id_pc       (id_pc),
    .id_off      (id_offset),
    .id_a        (id_opnd_a),
    .id_b        (id_opnd_b),
    .ifid_vld    (ifid_vld),
    .idex_vld    (idex_vld),
    .ex_br       (ex_br),
    .ex_pc       (ex_pc),
    .ex_off      (ex_off),
    .ex_a        (ex_a),
    .ex_b        (ex_b)
  );

  bfc_pc_reg #(.XLEN(XLEN), .RESET_PC(RESET_PC)) i_pc (
    .clk   (clk),
    .rst   (rst),
    .sel   (pc_sel),
    .target(redir_tgt),
    .pc_q  (fetch_pc)
  );

  always_comb begin
    flush_ifid = redirect;
    flush_idex = ex_fire;
    id_valid   = ifid_vld;
    ex_valid   = idex_vld;
  end

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (fetch_pc == RESET_PC && !id_valid && !ex_valid));

  // R2
  seq_advance_chk: assert property (@(posedge clk) disable iff (rst)
    (!hazard_stall && !flush_ifid) |=> fetch_pc == $past(fetch_pc) + XLEN'(INSN_BYTES));

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (hazard_stall && !flush_ifid) |=> ($stable(fetch_pc) && !ex_valid));

  // R5
  ex_flush_pair_chk: assert property (@(posedge clk) disable iff (rst)
    flush_idex |-> flush_ifid);

  // R6
  id_mode_single_chk: assert property (@(posedge clk) disable iff (rst)
    resolve_in_id |-> !flush_idex);

  // R7
  ex_bubble_chk: assert property (@(posedge clk) disable iff (rst)
    flush_idex |=> !ex_valid);

  // R10
  stall_override_chk: assert property (@(posedge clk) disable iff (rst)
    (flush_ifid && !flush_idex && hazard_stall) |=> ex_valid);
endmodule

// File: tb/test_bfc_flush_ctrl.sv
`timescale 1ns/1ps
module test_bfc_flush_ctrl;
  localparam int XLEN  = 32;
  localparam int OFS_W = 12;
  localparam int DEPTH = 64;
  localparam int NRET  = 16;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             resolve_in_id = 1'b0;
  logic             hazard_stall = 1'b0;
  logic             id_is_branch;
  logic [XLEN-1:0]  id_pc, id_opnd_a, id_opnd_b;
  logic [OFS_W-1:0] id_offset;
  logic [XLEN-1:0]  fetch_pc;
  logic             flush_ifid, flush_idex, id_valid, ex_valid;

  always #10 clk = ~clk;

  logic             br_m  [DEPTH];
  logic             eq_m  [DEPTH];
  logic [OFS_W-1:0] off_m [DEPTH];
  logic [XLEN-1:0]  ifid_pc, ex_pc;

  assign id_pc        = ifid_pc;
  assign id_is_branch = br_m[ifid_pc[7:2]];
  assign id_offset    = off_m[ifid_pc[7:2]];
  assign id_opnd_a    = ifid_pc;
  assign id_opnd_b    = eq_m[ifid_pc[7:2]] ? ifid_pc : (ifid_pc ^ 32'd1);

  bfc_flush_ctrl #(.XLEN(XLEN), .OFS_W(OFS_W), .RESET_PC('0)) i_bfc_flush_ctrl (
    .clk(clk), .rst(rst), .resolve_in_id(resolve_in_id), .hazard_stall(hazard_stall),
    .id_is_branch(id_is_branch), .id_pc(id_pc), .id_offset(id_offset),
    .id_opnd_a(id_opnd_a), .id_opnd_b(id_opnd_b), .fetch_pc(fetch_pc),
    .flush_ifid(flush_ifid), .flush_idex(flush_idex), .id_valid(id_valid), .ex_valid(ex_valid)
  );

  // pipeline registers of the surrounding environment
  always @(posedge clk) begin
    if (rst) begin
      ifid_pc <= '0;
      ex_pc   <= '0;
    end else begin
      ex_pc <= ifid_pc;
      if (!(hazard_stall && !flush_ifid)) ifid_pc <= fetch_pc;
    end
  end

  int n_cmp = 0;
  int n_bad = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic put(input int i, input bit eq, input int o);
    br_m[i]  = 1'b1;
    eq_m[i]  = eq;
    off_m[i] = OFS_W'(o);
  endtask

  task automatic load_prog(input int p);
    for (int i = 0; i < DEPTH; i++) begin
      br_m[i] = 1'b0; eq_m[i] = 1'b0; off_m[i] = '0;
    end
    if (p == 1) begin
      put(5, 1, 20); put(6, 1, 30); put(7, 1, 40);
      put(25, 0, 5); put(26, 1, -24);
    end else if (p == 2) begin
      put(3, 0, 9); put(12, 1, -10);
    end
  endtask

  task automatic run(input bit mode_id, input int prog, input int smode, input string req_t);
    int exp_pc [NRET];
    int exp_t  [NRET];
    int got_pc [NRET];
    int got_t  [NRET];
    int pc, t, nret, cyc, nfi, nfe, idx;
    load_prog(prog);
    pc = 0; t = 2;
    for (int k = 0; k < NRET; k++) begin
      if (smode == 1) begin
        while (((t - 1) % 5) == 2) t++;
      end
      exp_pc[k] = pc;
      exp_t[k]  = t;
      idx = (pc >> 2) % DEPTH;
      if (br_m[idx] && eq_m[idx]) begin
        pc = pc + 4 * int'($signed(off_m[idx]));
        t  = t + 1 + (mode_id ? 1 : 2);
      end else begin
        pc = pc + 4;
        t  = t + 1;
      end
    end
    resolve_in_id = mode_id;
    hazard_stall  = 1'b0;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1
    check(fetch_pc == '0 && !id_valid && !ex_valid && !flush_ifid && !flush_idex,
          "R1", "reset state", longint'(fetch_pc), 0);
    rst = 1'b0;
    cyc = 0; nret = 0; nfi = 0; nfe = 0;
    while (nret < NRET && cyc < 300) begin
      if (ex_valid) begin
        got_pc[nret] = int'(ex_pc);
        got_t[nret]  = cyc;
        nret++;
      end
      if (flush_ifid) nfi++;
      if (flush_idex) nfe++;
      if (prog == 0 && smode == 0 && cyc < 12)
        check(fetch_pc == XLEN'(4 * cyc), "R2", "fetch_pc step",
              longint'(fetch_pc), longint'(4 * cyc));
      if (smode == 1)
        hazard_stall = (cyc % 5) == 2;
      else if (smode == 2) begin
        if (mode_id)
          hazard_stall = id_valid && br_m[ifid_pc[7:2]] && eq_m[ifid_pc[7:2]];
        else
          hazard_stall = ex_valid && br_m[ex_pc[7:2]] && eq_m[ex_pc[7:2]];
      end else
        hazard_stall = 1'b0;
      @(negedge clk);
      cyc++;
    end
    hazard_stall = 1'b0;
    check(nret == NRET, req_t, "retire count", nret, NRET);
    for (int k = 0; k < nret; k++) begin
      // R7 R8: architectural order, no wrong-path redirect
      check(got_pc[k] == exp_pc[k], "R7/R8", $sformatf("%s retired pc #%0d", req_t, k),
            got_pc[k], exp_pc[k]);
      // R3 R4 plus scenario requirement: cycle of retirement
      check(got_t[k] == exp_t[k], $sformatf("R3/R4/%s", req_t),
            $sformatf("retire cycle #%0d", k), got_t[k], exp_t[k]);
    end
    if (mode_id)
      check(nfe == 0, "R6", "ID/EX flushes in decode mode", nfe, 0);
    else
      check(nfe == nfi, "R5", "paired flushes in execute mode", nfe, nfi);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    run(1'b0, 0, 0, "R2");
    run(1'b1, 0, 0, "R2");
    run(1'b0, 1, 0, "R5");
    run(1'b1, 1, 0, "R6");
    run(1'b0, 2, 0, "R4");
    run(1'b1, 2, 0, "R4");
    run(1'b0, 0, 1, "R9");
    run(1'b1, 0, 1, "R9");
    run(1'b0, 1, 2, "R10");
    run(1'b1, 1, 2, "R10");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule